// File: doc/BRIEF.md
# Gated-Enable Parallel/Serial-In Shift Register

This block is an eight-stage register whose last stage forms a serial output stream. The stages can be filled in two ways: one bit at a time from a serial input that enters the first stage, or all at once from a broadside parallel word. A mode select chooses between shifting and loading. A hold input freezes every stage while the system clock keeps running, so the block is stopped on command without gating its clock.

The design is fully synchronous to one clock. The hold input is a clock enable sampled on the rising edge. The active-low clear empties the register at once, with no clock needed. Its release reaches the stages through a two-flop synchroniser, so the first edge that acts after a clear is well defined. All stages are also brought out on a debug port so that a checker can compare them cycle by cycle.

Top module: `piso_shift_reg`

## Requirements
- R1: The register has WIDTH (default 8) stages. Stage index 0 is the first stage and index WIDTH-1 is the last. `q_o` always equals the last stage, and bit k of `stages_o` is stage k.
- R2: With `shift_nload_i`=1 and `hold_i`=0, a rising edge moves stage k-1 into stage k for every k≥1 and loads `ser_i` into stage 0.
- R3: With `shift_nload_i`=0 and `hold_i`=0, a rising edge copies `par_i[k]` into stage k for every k.
- R4: During a parallel load `ser_i` has no effect on any stage.
- R5: With `hold_i`=1, every stage keeps its value across a rising edge, whatever the mode, serial and parallel inputs are.
- R6: While `rst_ni` is 0, all stages are 0 at once, with no clock edge needed, and the clear overrides every other input.
- R7: After `rst_ni` returns to 1, the first two rising edges leave the stages at 0. The third rising edge is the first one that shifts or loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, rising edge active |
| rst_ni | input | 1 | Active-low clear. Asserts asynchronously and releases through the synchroniser |
| shift_nload_i | input | 1 | 1 selects a serial shift, 0 selects a parallel load |
| hold_i | input | 1 | 1 freezes all stages (clock enable, active low) |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data. Bit k goes to stage k |
| q_o | output | 1 | Last stage, the serial output |
| stages_o | output | WIDTH | Debug view of all stages |

## Verification
On every clocked cycle, assertions check the shift relation between consecutive stages, the copy of the parallel word on a load, the freeze under hold, the all-zero state while the clear is low, and that the synchronised release stays low one edge after the clear is released. Some behaviour depends on a sequence of several steps, and only the bench scenarios show it. This covers the order in which the bits of a loaded word come out of the serial output, the exact edge at which the register wakes up after a clear, and the clear acting between clock edges.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_SHIFT = 2'd1,
    MODE_LOAD  = 2'd2
  } stage_mode_e;
endpackage

// File: rtl/piso_rst_sync.sv
module piso_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];

  // R7: release is not seen on the first edge after the clear goes away
  a_r7_release_delayed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |=> !rst_no);
endmodule

// File: rtl/piso_stage.sv
module piso_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic load_i,
  input  logic shift_in_i,
  input  logic par_in_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= 1'b0;
    else if (en_i) q_o <= load_i ? par_in_i : shift_in_i;
  end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_nload_i,
  input  logic             hold_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             q_o,
  output logic [WIDTH-1:0] stages_o
);
  localparam int LAST = WIDTH - 1;

  logic             rst_int_n;
  stage_mode_e      mode;
  logic             en, load;
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] shift_src;

  piso_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_int_n)
  );

  always_comb begin
    if (hold_i)             mode = MODE_HOLD;
    else if (shift_nload_i) mode = MODE_SHIFT;
    else                    mode = MODE_LOAD;
  end

  assign en   = (mode != MODE_HOLD);
  assign load = (mode == MODE_LOAD);

  assign shift_src[0] = ser_i;

  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    if (k > 0) begin : g_link
      assign shift_src[k] = stage_q[k-1];
    end
    piso_stage u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_int_n),
      .en_i       (en),
      .load_i     (load),
      .shift_in_i (shift_src[k]),
      .par_in_i   (par_i[k]),
      .q_o        (stage_q[k])
    );
  end

  assign q_o      = stage_q[LAST];
  assign stages_o = stage_q;

  // R2: shift moves every stage one place up, serial enters at 0
  a_r2_shift: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (shift_nload_i && !hold_i) |=> (stages_o == {$past(stages_o[WIDTH-2:0]), $past(ser_i)}));

  // R3, R4: load copies the parallel word, serial input plays no part
  a_r3_load: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    (!shift_nload_i && !hold_i) |=> (stages_o == $past(par_i)));

  // R5: hold freezes all stages
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_int_n)
    hold_i |=> $stable(stages_o));

  // R6: clear forces zero
  a_r6_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (stages_o == '0));
endmodule

// File: tb/sim_piso_shift_reg.sv
module sim_piso_shift_reg;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_nload = 1'b1;
  logic         hold = 1'b1;
  logic         ser = 1'b0;
  logic [W-1:0] par = '0;
  logic         q;
  logic [W-1:0] stages;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  piso_shift_reg #(.WIDTH(W)) u0 (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .shift_nload_i (shift_nload),
    .hold_i        (hold),
    .ser_i         (ser),
    .par_i         (par),
    .q_o           (q),
    .stages_o      (stages)
  );

  task automatic chk(input string req, input logic [W-1:0] exp_stages);
    checks++;
    if (stages !== exp_stages) begin
      fails++;
      $display("FAIL %s stages actual=%h expected=%h", req, stages, exp_stages);
    end
    checks++;
    if (q !== exp_stages[W-1]) begin
      fails++;
      $display("FAIL %s q_o actual=%b expected=%b", req, q, exp_stages[W-1]);
    end
  endtask

  // {shift_nload, hold, ser, par, expected stages after the edge, req number}
  localparam int VW = 3 + W + W + 8;
  localparam logic [VW-1:0] VEC [16] = '{
    {3'b101, 8'h00, 8'h01, 8'd2},  // R2 shift in 1
    {3'b101, 8'hFF, 8'h03, 8'd2},  // R2 par ignored
    {3'b100, 8'h00, 8'h06, 8'd2},
    {3'b101, 8'h00, 8'h0D, 8'd2},
    {3'b110, 8'hFF, 8'h0D, 8'd5},  // R5 hold during shift
    {3'b011, 8'hFF, 8'h0D, 8'd5},  // R5 hold during load
    {3'b001, 8'hAB, 8'hAB, 8'd4},  // R3 R4 load 10101011, ser=1 ignored
    {3'b100, 8'h00, 8'h56, 8'd1},  // R1 serial order of loaded word
    {3'b100, 8'h00, 8'hAC, 8'd1},
    {3'b100, 8'h00, 8'h58, 8'd1},
    {3'b100, 8'h00, 8'hB0, 8'd1},
    {3'b100, 8'h00, 8'h60, 8'd1},
    {3'b100, 8'h00, 8'hC0, 8'd1},
    {3'b100, 8'h00, 8'h80, 8'd1},
    {3'b100, 8'h00, 8'h00, 8'd1},
    {3'b000, 8'h5A, 8'h5A, 8'd3}   // R3 second load pattern
  };

  initial begin
    #(8 * 5000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R6 reset state", 8'h00);

    // R7: load FF right at release; first two edges must not act
    rst_n = 1'b1; hold = 1'b0; shift_nload = 1'b0; par = 8'hFF;
    @(posedge clk); @(negedge clk); chk("R7 edge1", 8'h00);
    @(posedge clk); @(negedge clk); chk("R7 edge2", 8'h00);
    @(posedge clk); @(negedge clk); chk("R7 edge3", 8'hFF);

    // R6: asynchronous clear between edges
    #1 rst_n = 1'b0;
    #1 chk("R6 async clear", 8'h00);
    @(negedge clk);
    rst_n = 1'b1; hold = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 after release under hold", 8'h00);

    for (int i = 0; i < 16; i++) begin
      {shift_nload, hold, ser, par} = VEC[i][VW-1:W+8];
      @(posedge clk);
      @(negedge clk);
      chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), VEC[i][W+7:8]);
    end

    // R6: clear overrides a load in progress
    hold = 1'b0; shift_nload = 1'b0; par = 8'hFF; rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 clear over load", 8'h00);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule